// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and two frame clocks for a serial audio port. One for transmit and one for receive. Everything runs from a single master audio clock. A 32-bit control word selects between two modes. In generating mode, the master clock is divided down to a bit clock, and each frame clock is derived from that bit clock by its own divider. In following mode, externally supplied bit and frame clocks are brought into the master-clock domain and passed through.

Serializers do not clock on the derived clocks. Instead they use two single-cycle enables in the master-clock domain: `launch_o` marks the bit-clock edge on which data is driven, and `sample_o` marks the edge on which data is captured. Every divider field holds the wanted ratio minus one.

Whenever a configuration field changes, or a transfer start is requested, the counters restart. The first bit-clock phase after a restart therefore always has full length.

Top module: `audio_clk_gen`

## Requirements
- R1: While reset is held and in the first cycle after it with a zero control word, `bclk_o`, `tx_fs_o`, `rx_fs_o`, `launch_o` and `sample_o` are all 0.
- R2: Generating mode applies when control bit 27 is 0. With bit-clock field ctrl[23:16] = m, the period of `bclk_o` is N = m+1 master cycles. A field of 0 is treated as 1, giving N = 2. With bit 26 clear, `bclk_o` is high for floor(N/2) cycles and low for the remaining cycles.
- R3: Setting control bit 26 inverts `bclk_o`. The high phase then lasts N - floor(N/2) cycles and the low phase floor(N/2) cycles.
- R4: `launch_o` is 1 for exactly the first cycle in which `bclk_o` is low after being high. `sample_o` is 1 for exactly the first cycle in which `bclk_o` is high after being low. Both rules hold in either mode.
- R5: With transmit field ctrl[7:0] = t, the transmit frame ratio is T = t+1 bit clocks. A field of 0 is treated as 1. `tx_fs_o` is low for floor(T/2) bit clocks and high for the rest. In generating mode it changes only in the cycle after a `launch_o` strobe.
- R6: The receive frame ratio comes from ctrl[15:8] with the same rules as R5 and drives `rx_fs_o`. It is independent of the transmit field.
- R7: A 1 on `start_i`, or a change in any of ctrl[27:26] or ctrl[23:0], restarts the dividers. Two master cycles later, `bclk_o` begins a full-length raw-high phase and both frame clocks are low.
- R8: In following mode (bit 27 = 1), `bclk_o` equals `ext_bclk_i` XOR bit 26 as sampled two master cycles earlier. `tx_fs_o` and `rx_fs_o` equal `ext_txfs_i` and `ext_rxfs_i` as sampled two master cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: mode, polarity, three divider fields |
| start_i | input | 1 | Transfer start, restarts the dividers |
| ext_bclk_i | input | 1 | External bit clock (following mode) |
| ext_txfs_i | input | 1 | External transmit frame clock |
| ext_rxfs_i | input | 1 | External receive frame clock |
| bclk_o | output | 1 | Bit clock |
| tx_fs_o | output | 1 | Transmit frame clock |
| rx_fs_o | output | 1 | Receive frame clock |
| launch_o | output | 1 | Strobe on the data-launch edge of the bit clock |
| sample_o | output | 1 | Strobe on the data-sample edge of the bit clock |

## Verification
Each result has a fixed latency from its stimulus:
- A start request or a configuration change takes effect two master cycles later.
- External clocks reach the outputs two cycles after they are sampled.
- Strobes accompany the bit-clock edge in the same cycle.
- A frame clock moves one cycle after a launch strobe.

The bench drives inputs on the falling clock edge and samples on later falling edges, at exactly those offsets. Periods and phase lengths are measured as run lengths of whole master cycles. They are then compared with N, T and the floor/ceiling halves, computed arithmetically for each swept configuration.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int DIV_W     = 8;
  localparam int CTRL_W    = 32;
  localparam int MODE_BIT  = 27;
  localparam int INV_BIT   = 26;
  localparam int BDIV_LSB  = 16;
  localparam int RXDIV_LSB = 8;
  localparam int TXDIV_LSB = 0;
  localparam logic [CTRL_W-1:0] CFG_MASK = 32'h0CFF_FFFF;

  typedef struct packed {
    logic             follow;
    logic             inv;
    logic [DIV_W-1:0] bdiv;
    logic [DIV_W-1:0] rxdiv;
    logic [DIV_W-1:0] txdiv;
  } cfg_t;

  function automatic cfg_t decode(input logic [CTRL_W-1:0] w);
    cfg_t c;
    c.follow = w[MODE_BIT];
    c.inv    = w[INV_BIT];
    c.bdiv   = w[BDIV_LSB  +: DIV_W];
    c.rxdiv  = w[RXDIV_LSB +: DIV_W];
    c.txdiv  = w[TXDIV_LSB +: DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         phase_o
);
  logic [W-1:0] last, half, cnt_q, cnt_inc;
  logic         ph_q;

  always_comb begin
    last    = (div_i == '0) ? W'(1) : div_i;
    half    = W'(({1'b0, last} + (W+1)'(1)) >> 1);
    cnt_inc = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (restart_i || cnt_q >= last) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      ph_q  <= (cnt_inc < half);
    end
  end

  assign phase_o = ph_q;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> cnt_q <= last);
  p_restart_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && ph_q));
endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         fs_o
);
  logic [W-1:0] last, half, cnt_q, cnt_nxt;
  logic         fs_q;

  always_comb begin
    last    = (div_i == '0) ? W'(1) : div_i;
    half    = W'(({1'b0, last} + (W+1)'(1)) >> 1);
    cnt_nxt = (cnt_q >= last) ? '0 : cnt_q + W'(1);
  end

  // Preload last so the first launch edge opens the left half.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fs_q  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= last;
      fs_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_nxt;
      fs_q  <= (cnt_nxt >= half);
    end
  end

  assign fs_o = fs_q;

  p_fs_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q != $past(fs_q)) |-> ($past(tick_i) || $past(restart_i)));
endmodule

// File: rtl/aclk_sync.sv
module aclk_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import aclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              start_i,
  input  logic              ext_bclk_i,
  input  logic              ext_txfs_i,
  input  logic              ext_rxfs_i,
  output logic              bclk_o,
  output logic              tx_fs_o,
  output logic              rx_fs_o,
  output logic              launch_o,
  output logic              sample_o
);
  localparam int NFS = 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic              restart_q, cfg_chg;
  cfg_t              cfg;
  logic              ph, mst_bclk, mst_d1, mst_fall, bclk_d1;
  logic [DIV_W-1:0]  fdiv [NFS];
  logic [NFS-1:0]    fs_int;
  logic [2:0]        ext_s;

  assign cfg_chg = ((ctrl_i ^ ctrl_q) & CFG_MASK) != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_i;
      restart_q <= start_i | cfg_chg;
    end
  end

  assign cfg = decode(ctrl_q);

  aclk_bit_div #(.W(DIV_W)) u_bdiv (
    .clk_i, .rst_ni, .restart_i(restart_q), .div_i(cfg.bdiv), .phase_o(ph)
  );

  assign mst_bclk = ph ^ cfg.inv;
  assign mst_fall = mst_d1 & ~mst_bclk;

  assign fdiv[0] = cfg.txdiv;
  assign fdiv[1] = cfg.rxdiv;

  for (genvar g = 0; g < NFS; g++) begin : g_fs
    aclk_frame_div #(.W(DIV_W)) u_fdiv (
      .clk_i, .rst_ni, .restart_i(restart_q), .tick_i(mst_fall),
      .div_i(fdiv[g]), .fs_o(fs_int[g])
    );
  end

  aclk_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({ext_rxfs_i, ext_txfs_i, ext_bclk_i}), .q_o(ext_s)
  );

  always_comb begin
    if (cfg.follow) begin
      bclk_o  = ext_s[0] ^ cfg.inv;
      tx_fs_o = ext_s[1];
      rx_fs_o = ext_s[2];
    end else begin
      bclk_o  = mst_bclk;
      tx_fs_o = fs_int[0];
      rx_fs_o = fs_int[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_d1  <= 1'b0;
      bclk_d1 <= 1'b0;
    end else begin
      mst_d1  <= mst_bclk;
      bclk_d1 <= bclk_o;
    end
  end

  assign launch_o = bclk_d1 & ~bclk_o;
  assign sample_o = ~bclk_d1 & bclk_o;

  p_launch_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
  p_sample_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
endmodule

// File: tb/sim_audio_clk_gen.sv
module sim_audio_clk_gen;
  logic        clk = 0, rst_ni = 0;
  logic [31:0] ctrl_i = '0;
  logic        start_i = 0, ext_bclk_i = 0, ext_txfs_i = 0, ext_rxfs_i = 0;
  logic        bclk_o, tx_fs_o, rx_fs_o, launch_o, sample_o;

  int total = 0, bad = 0, mon_bad = 0;
  bit mon_en = 0, done = 0;
  logic pb = 0, pl = 0, ptx = 0, prx = 0;

  always #10 clk = ~clk;

  audio_clk_gen u0 (
    .clk_i(clk), .rst_ni, .ctrl_i, .start_i, .ext_bclk_i, .ext_txfs_i,
    .ext_rxfs_i, .bclk_o, .tx_fs_o, .rx_fs_o, .launch_o, .sample_o
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit fol, bit inv, int b, int r, int t);
    return {4'b0, fol, inv, 2'b0, b[7:0], r[7:0], t[7:0]};
  endfunction

  function automatic logic pick(int s);
    case (s)
      0: return bclk_o;
      1: return tx_fs_o;
      default: return rx_fs_o;
    endcase
  endfunction

  // R4 strobes, R5/R6 frame edges only after a launch strobe (generating mode)
  always @(negedge clk) begin
    if (mon_en) begin
      if (launch_o !== (pb & ~bclk_o) || sample_o !== (~pb & bclk_o)) mon_bad++;
      if (!ctrl_i[27] && ((tx_fs_o !== ptx) || (rx_fs_o !== prx)) && !pl) mon_bad++;
    end
    pb = bclk_o; pl = launch_o; ptx = tx_fs_o; prx = rx_fs_o;
  end

  task automatic run_len(int s, output int hi, output int lo);
    int g;
    hi = 0; lo = 0;
    g = 0; while (pick(s) == 1'b1 && g < 5000) begin @(negedge clk); g++; end
    g = 0; while (pick(s) == 1'b0 && g < 5000) begin @(negedge clk); g++; end
    while (pick(s) == 1'b1 && hi < 5000) begin @(negedge clk); hi++; end
    while (pick(s) == 1'b0 && lo < 5000) begin @(negedge clk); lo++; end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    mon_en = 0;
    ctrl_i = w; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    mon_bad = 0;
    mon_en = 1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, n, t, r, tp, rp, run;
    int tl[3];
    int rl[3];
    logic [2:0] hist [24];
    tl = '{0, 6, 4}; rl = '{3, 0, 2};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bclk_o === 0 && launch_o === 0 && sample_o === 0, "R1 bclk/strobes in reset", int'(bclk_o), 0);
    check(tx_fs_o === 0 && rx_fs_o === 0, "R1 frames in reset", int'(tx_fs_o), 0);
    rst_ni = 1;
    @(negedge clk);
    check(bclk_o === 0 && tx_fs_o === 0 && rx_fs_o === 0 && launch_o === 0 && sample_o === 0,
          "R1 after release", int'({bclk_o, tx_fs_o, rx_fs_o, launch_o, sample_o}), 0);

    // R2 R3 R5 R6 R4 sweep
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < 3; k++) begin
          n = (m == 0) ? 2 : m + 1;
          t = ((tl[k] == 0) ? 1 : tl[k]) + 1;
          r = ((rl[k] == 0) ? 1 : rl[k]) + 1;
          apply(mk(0, p[0], m, rl[k], tl[k]));
          run_len(0, hi, lo);
          if (p == 0) begin
            check(hi == n / 2, "R2 bclk high", hi, n / 2);
            check(lo == n - n / 2, "R2 bclk low", lo, n - n / 2);
          end else begin
            check(hi == n - n / 2, "R3 inverted high", hi, n - n / 2);
            check(lo == n / 2, "R3 inverted low", lo, n / 2);
          end
          run_len(1, hi, lo);
          check(hi == (t - t / 2) * n, "R5 tx frame high", hi, (t - t / 2) * n);
          check(lo == (t / 2) * n, "R5 tx frame low", lo, (t / 2) * n);
          run_len(2, hi, lo);
          check(hi == (r - r / 2) * n, "R6 rx frame high", hi, (r - r / 2) * n);
          check(lo == (r / 2) * n, "R6 rx frame low", lo, (r / 2) * n);
          check(mon_bad == 0, "R4 strobes and R5 frame edge timing", mon_bad, 0);
        end
      end
    end

    // R7 restart by start_i and by divider change
    apply(mk(0, 0, 5, 3, 3));
    repeat (4) @(negedge clk);
    mon_en = 0;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    @(negedge clk);
    check(tx_fs_o === 0 && rx_fs_o === 0, "R7 frames low after start", int'(tx_fs_o), 0);
    run = 0;
    while (bclk_o == 1'b1 && run < 100) begin run++; @(negedge clk); end
    check(run == 3, "R7 full phase after start", run, 3);
    repeat (2) @(negedge clk);
    ctrl_i = mk(0, 0, 7, 3, 3);
    @(negedge clk);
    @(negedge clk);
    run = 0;
    while (bclk_o == 1'b1 && run < 100) begin run++; @(negedge clk); end
    check(run == 4, "R7 full phase after divider change", run, 4);
    run_len(0, hi, lo);
    check(hi + lo == 8, "R7 new period", hi + lo, 8);

    // R8 following mode, both polarities
    for (int p = 0; p < 2; p++) begin
      apply(mk(1, p[0], 3, 3, 3));
      tp = 0; rp = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (k >= 2) begin
          if (bclk_o !== (hist[k-2][0] ^ p[0])) tp++;
          if (tx_fs_o !== hist[k-2][1] || rx_fs_o !== hist[k-2][2]) rp++;
        end
        hist[k] = {k[3] ^ k[0], k[1], k[0] ^ k[2]};
        {ext_rxfs_i, ext_txfs_i, ext_bclk_i} = hist[k];
      end
      check(tp == 0, "R8 bclk follows external", tp, 0);
      check(rp == 0, "R8 frames follow external", rp, 0);
      check(mon_bad == 0, "R4 strobes in following mode", mon_bad, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule